// File: doc/BRIEF.md
# I/O Translation Register Block

This block holds the software-visible configuration and fault state of an I/O address translation unit. A host reaches it through a plain 32-bit register port with byte addresses, one word per request. Every named register has its own write mask and forced bits. A write to the control register also works out the base address of the translated I/O window and exports it to the translator.

The translator has a capture port that loads the fault status and fault address registers when a translation fails. A capture outranks a host write to those registers in the same cycle. Offsets with no named register store whole words in a small scratch area, but only below a parameterised word count in each 4 KB page. Every other offset reads zero.

Top module: `iou_regfile`

## Requirements
- R1: After reset the control word reads 0x04000000, every other register and scratch word reads 0, and `win_base` is 0.
- R2: A write to the control word at offset 0x000 stores the written value ANDed with 0x0000001D and ORed with 0x04000000, so bits 31:24 always read 0x04.
- R3: The range code is control write data bits 4:2. On the clock edge of a control write, `win_base` becomes 0xFF000000 shifted left by that code, so code 0 gives 0xFF000000 and code 7 gives 0x80000000. At all other times `win_base` holds its value.
- R4: The page-table base word at offset 0x004 keeps only the written bits in mask 0x07FFFC00.
- R5: Four slot configuration words sit at offsets 0x1010, 0x1014, 0x1018 and 0x101C. Each keeps only the written bits in mask 0x00010003, and each is independent of the others.
- R6: The arbitration word at offset 0x2000 stores the written value ANDed with 0x001F0000 and ORed with 0x00000008.
- R7: The whole-TLB flush word (0x014) and the single-page flush word (0x018) keep all 32 written bits.
- R8: The fault status word (0x1000) and fault address word (0x1004) store host writes unmasked. A cycle with `cap_valid` high loads the status word with 0xC0820000, with bit 18 also set when `cap_is_read` is 1, and loads the address word with `cap_addr`.
- R9: When a capture and a host write to either fault word occur in the same cycle, the capture value is stored.
- R10: An offset with no named register, within pages 0 to 2 and with word index below SCRATCH_WORDS (16) inside its 4 KB page, stores the full written word. Any other unnamed offset reads 0 and ignores writes.
- R11: `req_ready` is high in every cycle in which `req_valid` is high. Read data appears combinationally in that same cycle, and address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Byte address inside the block |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted this cycle |
| rd_data | output | 32 | Read data for the current request |
| cap_valid | input | 1 | Fault capture strobe from the translator |
| cap_is_read | input | 1 | Faulting access was a read |
| cap_addr | input | 32 | Faulting I/O address |
| win_base | output | 32 | Base of the translated I/O window |

## Verification
The hardest case to reach from the ports is a fault capture that lands in the very cycle in which the host writes a fault word. The driver has a combined task that raises the capture strobe and the write request on the same falling edge. The scoreboard then reads both fault words and expects the capture values. The bench also walks all eight range codes and checks `win_base` one cycle after each control write. It then writes other registers and confirms that the window base has not moved.

// File: rtl/iou_pkg.sv
package iou_pkg;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned PAGE_SH = 12;
   localparam int unsigned NPAGES  = 3;

   // page / word-in-page locations of named registers
   localparam int unsigned PG_CTL  = 0;
   localparam int unsigned WD_CTL  = 0;
   localparam int unsigned WD_PTB  = 1;
   localparam int unsigned WD_TFL  = 5;
   localparam int unsigned WD_PFL  = 6;
   localparam int unsigned PG_FLT  = 1;
   localparam int unsigned WD_FST  = 0;
   localparam int unsigned WD_FAD  = 1;
   localparam int unsigned WD_SLOT = 4;
   localparam int unsigned NSLOTS  = 4;
   localparam int unsigned PG_ARB  = 2;
   localparam int unsigned WD_ARB  = 0;

   localparam logic [WORD_W-1:0] CTL_MASK  = 32'h0000_001D;
   localparam logic [WORD_W-1:0] CTL_FORCE = 32'h0400_0000;
   localparam logic [WORD_W-1:0] PTB_MASK  = 32'h07FF_FC00;
   localparam logic [WORD_W-1:0] SLT_MASK  = 32'h0001_0003;
   localparam logic [WORD_W-1:0] ARB_MASK  = 32'h001F_0000;
   localparam logic [WORD_W-1:0] ARB_FORCE = 32'h0000_0008;
   localparam logic [WORD_W-1:0] ALL_ONES  = 32'hFFFF_FFFF;

   localparam int unsigned RANGE_LSB = 2;
   localparam int unsigned RANGE_W   = 3;
   localparam logic [WORD_W-1:0] WIN_SMALLEST = 32'hFF00_0000;

   // fault status composition on capture
   localparam logic [WORD_W-1:0] FLT_ANY     = 32'h8000_0000;
   localparam logic [WORD_W-1:0] FLT_LATE    = 32'h4000_0000;
   localparam logic [WORD_W-1:0] FLT_RSVD    = 32'h0080_0000;
   localparam logic [WORD_W-1:0] FLT_ISREAD  = 32'h0004_0000;
   localparam logic [WORD_W-1:0] FLT_ADRVLD  = 32'h0002_0000;

   function automatic logic [WORD_W-1:0] win_for_code(input logic [RANGE_W-1:0] code);
      return WIN_SMALLEST << code;
   endfunction

   function automatic logic [WORD_W-1:0] fault_word(input logic is_read);
      return FLT_ANY | FLT_LATE | FLT_RSVD | FLT_ADRVLD | (is_read ? FLT_ISREAD : '0);
   endfunction
endpackage

// File: rtl/iou_masked_reg.sv
module iou_masked_reg #(
   parameter int unsigned W = 32,
   parameter logic [W-1:0] MASK  = '1,
   parameter logic [W-1:0] FORCE = '0,
   parameter logic [W-1:0] RST   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   if (W == 0) begin : g_bad_w
      $error("iou_masked_reg: W must be non-zero");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= (wdata & MASK) | FORCE;
   end
endmodule

// File: rtl/iou_ctrl_reg.sv
module iou_ctrl_reg
   import iou_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] q,
   output logic [WORD_W-1:0] win_base
);
   logic [RANGE_W-1:0] code_w;
   assign code_w = wdata[RANGE_LSB +: RANGE_W];

   iou_masked_reg #(.W(WORD_W), .MASK(CTL_MASK), .FORCE(CTL_FORCE), .RST(CTL_FORCE)) u_word (
      .clk(clk), .rst_n(rst_n), .we(we), .wdata(wdata), .q(q)
   );

   // window base is decoded from the written code, not from the stored word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  win_base <= '0;
      else if (we) win_base <= win_for_code(code_w);
   end
endmodule

// File: rtl/iou_fault_regs.sv
module iou_fault_regs
   import iou_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_we,
   input  logic              ad_we,
   input  logic [WORD_W-1:0] wdata,
   input  logic              cap_valid,
   input  logic              cap_is_read,
   input  logic [WORD_W-1:0] cap_addr,
   output logic [WORD_W-1:0] fsr_q,
   output logic [WORD_W-1:0] far_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsr_q <= '0;
         far_q <= '0;
      end else if (cap_valid) begin
         fsr_q <= fault_word(cap_is_read);
         far_q <= cap_addr;
      end else begin
         if (st_we) fsr_q <= wdata;
         if (ad_we) far_q <= wdata;
      end
   end
endmodule

// File: rtl/iou_scratch.sv
module iou_scratch #(
   parameter int unsigned W       = 32,
   parameter int unsigned ENTRIES = 48,
   localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [W-1:0]     wdata,
   output logic [W-1:0]     rdata
);
   if (ENTRIES == 0 || ENTRIES > 4096) begin : g_bad_depth
      $error("iou_scratch: ENTRIES out of range");
   end

   logic [W-1:0] mem [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            mem[e] <= '0;
         else if (we && int'(idx) == e)         mem[e] <= wdata;
      end
   end

   assign rdata = (int'(idx) < ENTRIES) ? mem[idx] : '0;
endmodule

// File: rtl/iou_regfile.sv
module iou_regfile
   import iou_pkg::*;
#(
   parameter int unsigned ADDR_W        = 14,
   parameter int unsigned SCRATCH_WORDS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              req_ready,
   output logic [31:0]       rd_data,
   input  logic              cap_valid,
   input  logic              cap_is_read,
   input  logic [31:0]       cap_addr,
   output logic [31:0]       win_base
);
   localparam int unsigned PG_W      = ADDR_W - PAGE_SH;
   localparam int unsigned WD_W      = PAGE_SH - 2;
   localparam int unsigned SCR_N     = NPAGES * SCRATCH_WORDS;
   localparam int unsigned SCR_IDX_W = (SCR_N > 1) ? $clog2(SCR_N) : 1;

   if (ADDR_W < 14) begin : g_bad_addr
      $error("iou_regfile: ADDR_W must reach the third page");
   end
   if (SCRATCH_WORDS == 0 || SCRATCH_WORDS > 1024) begin : g_bad_scr
      $error("iou_regfile: SCRATCH_WORDS must be 1..1024");
   end

   // ---------------- address split ----------------
   logic [PG_W-1:0] page;
   logic [WD_W-1:0] word;
   logic [1:0]      unused_lsb;
   assign page       = req_addr[ADDR_W-1:PAGE_SH];
   assign word       = req_addr[PAGE_SH-1:2];
   assign unused_lsb = req_addr[1:0];

   logic wr;
   assign wr        = req_valid && req_write;
   assign req_ready = req_valid;

   function automatic logic at(input int unsigned pg, input int unsigned wd,
                               input logic [PG_W-1:0] p, input logic [WD_W-1:0] w);
      return (int'(p) == pg) && (int'(w) == wd);
   endfunction

   logic sel_ctl, sel_ptb, sel_tfl, sel_pfl, sel_fst, sel_fad, sel_arb;
   logic [NSLOTS-1:0] sel_slot;
   assign sel_ctl = at(PG_CTL, WD_CTL, page, word);
   assign sel_ptb = at(PG_CTL, WD_PTB, page, word);
   assign sel_tfl = at(PG_CTL, WD_TFL, page, word);
   assign sel_pfl = at(PG_CTL, WD_PFL, page, word);
   assign sel_fst = at(PG_FLT, WD_FST, page, word);
   assign sel_fad = at(PG_FLT, WD_FAD, page, word);
   assign sel_arb = at(PG_ARB, WD_ARB, page, word);

   // ---------------- named registers ----------------
   logic [31:0] ctl_q, ptb_q, tfl_q, pfl_q, fsr_q, far_q, arb_q;
   logic [31:0] slot_q [NSLOTS];

   iou_ctrl_reg u_ctl (
      .clk(clk), .rst_n(rst_n), .we(wr && sel_ctl), .wdata(req_wdata),
      .q(ctl_q), .win_base(win_base)
   );

   iou_masked_reg #(.W(32), .MASK(PTB_MASK)) u_ptb (
      .clk(clk), .rst_n(rst_n), .we(wr && sel_ptb), .wdata(req_wdata), .q(ptb_q)
   );
   iou_masked_reg #(.W(32), .MASK(ALL_ONES)) u_tfl (
      .clk(clk), .rst_n(rst_n), .we(wr && sel_tfl), .wdata(req_wdata), .q(tfl_q)
   );
   iou_masked_reg #(.W(32), .MASK(ALL_ONES)) u_pfl (
      .clk(clk), .rst_n(rst_n), .we(wr && sel_pfl), .wdata(req_wdata), .q(pfl_q)
   );
   iou_masked_reg #(.W(32), .MASK(ARB_MASK), .FORCE(ARB_FORCE)) u_arb (
      .clk(clk), .rst_n(rst_n), .we(wr && sel_arb), .wdata(req_wdata), .q(arb_q)
   );

   for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
      assign sel_slot[s] = at(PG_FLT, WD_SLOT + s, page, word);
      iou_masked_reg #(.W(32), .MASK(SLT_MASK)) u_slot (
         .clk(clk), .rst_n(rst_n), .we(wr && sel_slot[s]), .wdata(req_wdata), .q(slot_q[s])
      );
   end

   iou_fault_regs u_flt (
      .clk(clk), .rst_n(rst_n),
      .st_we(wr && sel_fst), .ad_we(wr && sel_fad), .wdata(req_wdata),
      .cap_valid(cap_valid), .cap_is_read(cap_is_read), .cap_addr(cap_addr),
      .fsr_q(fsr_q), .far_q(far_q)
   );

   // ---------------- scratch area ----------------
   logic any_named, scr_hit;
   logic [SCR_IDX_W-1:0] scr_idx;
   logic [31:0] scr_rd;

   assign any_named = sel_ctl | sel_ptb | sel_tfl | sel_pfl | sel_fst | sel_fad
                    | sel_arb | (|sel_slot);
   assign scr_hit   = !any_named && (int'(page) < NPAGES) && (int'(word) < SCRATCH_WORDS);

   always_comb begin
      int unsigned flat;
      flat    = int'(page) * SCRATCH_WORDS + int'(word);
      scr_idx = scr_hit ? SCR_IDX_W'(flat) : '0;
   end

   iou_scratch #(.W(32), .ENTRIES(SCR_N)) u_scr (
      .clk(clk), .rst_n(rst_n), .we(wr && scr_hit), .idx(scr_idx),
      .wdata(req_wdata), .rdata(scr_rd)
   );

   // ---------------- read mux ----------------
   always_comb begin
      rd_data = '0;
      if (sel_ctl)      rd_data = ctl_q;
      else if (sel_ptb) rd_data = ptb_q;
      else if (sel_tfl) rd_data = tfl_q;
      else if (sel_pfl) rd_data = pfl_q;
      else if (sel_fst) rd_data = fsr_q;
      else if (sel_fad) rd_data = far_q;
      else if (sel_arb) rd_data = arb_q;
      else if (scr_hit) rd_data = scr_rd;
      for (int s = 0; s < NSLOTS; s++)
         if (sel_slot[s]) rd_data = slot_q[s];
   end
endmodule

// File: rtl/iou_regfile_chk.sv
module iou_regfile_chk #(
   parameter int unsigned ADDR_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [31:0]       req_wdata,
   input logic              req_ready,
   input logic [31:0]       rd_data,
   input logic              cap_valid,
   input logic [31:0]       cap_addr,
   input logic [31:0]       win_base,
   input logic [31:0]       fsr_q,
   input logic [31:0]       far_q
);
   logic [ADDR_W-3:0] widx;
   logic rd, ctl_wr;
   assign widx   = req_addr[ADDR_W-1:2];
   assign rd     = req_valid && !req_write;
   assign ctl_wr = req_valid && req_write && (widx == '0);

   a_r2_ctl_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && widx == '0) |-> (rd_data[31:24] == 8'h04 && rd_data[23:5] == '0 && rd_data[1] == 1'b0));

   a_r3_win_update: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (win_base == (32'hFF00_0000 << $past(req_wdata[4:2]))));

   a_r3_win_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(win_base));

   a_r4_ptb_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && widx == (ADDR_W-2)'(1)) |-> ((rd_data & ~32'h07FF_FC00) == '0));

   a_r6_arb_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && widx == (ADDR_W-2)'(32'h800)) |-> ((rd_data & ~32'h001F_0008) == '0));

   a_r9_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |=> (far_q == $past(cap_addr) && fsr_q[31] && fsr_q[17]));

   a_r11_ready: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_ready);
endmodule

bind iou_regfile iou_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
   .rd_data(rd_data), .cap_valid(cap_valid), .cap_addr(cap_addr),
   .win_base(win_base), .fsr_q(fsr_q), .far_q(far_q)
);

// File: tb/iou_regfile_tb.sv
module iou_regfile_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [13:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready;
   logic [31:0] rd_data;
   logic        cap_valid = 1'b0, cap_is_read = 1'b0;
   logic [31:0] cap_addr = '0;
   logic [31:0] win_base;

   int n_chk = 0, n_fail = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #10 clk = ~clk;   // 50 MHz

   iou_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rd_data(rd_data), .cap_valid(cap_valid), .cap_is_read(cap_is_read),
      .cap_addr(cap_addr), .win_base(win_base)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 0; req_write = 0; cap_valid = 0; cap_is_read = 0;
   endtask

   task automatic wr(input logic [13:0] a, input logic [31:0] d);
      @(negedge clk);
      cap_valid = 0;
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
   endtask

   task automatic rd(input logic [13:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      cap_valid = 0;
      req_valid = 1; req_write = 0; req_addr = a;
      exp_q.push_back(e); tag_q.push_back(tag);
   endtask

   task automatic cap(input logic [31:0] fa, input logic isrd, input logic also_wr,
                      input logic [13:0] a, input logic [31:0] d);
      @(negedge clk);
      cap_valid = 1; cap_is_read = isrd; cap_addr = fa;
      req_valid = also_wr; req_write = also_wr; req_addr = a; req_wdata = d;
   endtask

   task automatic chk_win(input logic [31:0] e, input string tag);
      idle();
      #5 check(tag, win_base, e);
   endtask

   // scoreboard monitor: reads are compared mid-low-phase of the request cycle
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (req_valid) check("R11 ready", {31'b0, req_ready}, 32'd1);
         if (req_valid && !req_write) begin
            if (exp_q.size() == 0) check("R11 unexpected read", rd_data, 32'hxxxx_xxxx);
            else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
         end
      end
   end

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset values
      rd(14'h000, 32'h0400_0000, "R1 ctl reset");
      rd(14'h004, 32'h0, "R1 ptb reset");
      rd(14'h014, 32'h0, "R1 tlb flush reset");
      rd(14'h1010, 32'h0, "R1 slot reset");
      rd(14'h2000, 32'h0, "R1 arb reset");
      rd(14'h1000, 32'h0, "R1 fsr reset");
      rd(14'h1004, 32'h0, "R1 far reset");
      chk_win(32'h0, "R1 win reset");

      // R2 / R3 control masks and every range code
      wr(14'h000, 32'hFFFF_FFFF);
      rd(14'h000, 32'h0400_001D, "R2 ctl all ones");
      chk_win(32'h8000_0000, "R3 win code7");
      for (int c = 0; c < 8; c++) begin
         wr(14'h000, 32'(c) << 2 | 32'h1);
         chk_win(32'hFF00_0000 << c, "R3 win per code");
      end
      rd(14'h000, 32'h0400_001D, "R2 ctl code7 enabled");
      wr(14'h000, 32'hFFFF_FFE2);
      rd(14'h000, 32'h0400_0000, "R2 ctl masked bits dropped");
      chk_win(32'hFF00_0000, "R3 win code0 from masked write");

      // R4 / R7
      wr(14'h004, 32'hFFFF_FFFF);
      rd(14'h004, 32'h07FF_FC00, "R4 ptb mask");
      wr(14'h014, 32'hDEAD_BEEF);
      wr(14'h018, 32'h1234_5678);
      rd(14'h014, 32'hDEAD_BEEF, "R7 tlb flush");
      rd(14'h018, 32'h1234_5678, "R7 page flush");
      chk_win(32'hFF00_0000, "R3 win held over other writes");

      // R5 slots independent
      wr(14'h1010, 32'hFFFF_FFFF);
      wr(14'h1014, 32'h0000_0001);
      wr(14'h1018, 32'h0001_0000);
      wr(14'h101C, 32'hFFFE_FFFE);
      rd(14'h1010, 32'h0001_0003, "R5 slot0");
      rd(14'h1014, 32'h0000_0001, "R5 slot1");
      rd(14'h1018, 32'h0001_0000, "R5 slot2");
      rd(14'h101C, 32'h0000_0002, "R5 slot3");

      // R6 arbitration
      wr(14'h2000, 32'hFFFF_FFFF);
      rd(14'h2000, 32'h001F_0008, "R6 arb ones");
      wr(14'h2000, 32'h0);
      rd(14'h2000, 32'h0000_0008, "R6 arb zero write");

      // R8 fault words
      wr(14'h1000, 32'hA5A5_A5A5);
      wr(14'h1004, 32'h5A5A_5A5A);
      rd(14'h1000, 32'hA5A5_A5A5, "R8 fsr host write");
      rd(14'h1004, 32'h5A5A_5A5A, "R8 far host write");
      cap(32'h00AB_C000, 1'b1, 1'b0, 14'h0, 32'h0);
      rd(14'h1000, 32'hC086_0000, "R8 fsr read capture");
      rd(14'h1004, 32'h00AB_C000, "R8 far capture");
      cap(32'hFFF0_1000, 1'b0, 1'b0, 14'h0, 32'h0);
      rd(14'h1000, 32'hC082_0000, "R8 fsr write capture");

      // R9 capture beats a same-cycle write
      cap(32'h7777_0000, 1'b0, 1'b1, 14'h1000, 32'h1111_1111);
      rd(14'h1000, 32'hC082_0000, "R9 fsr capture wins");
      cap(32'h3333_3000, 1'b1, 1'b1, 14'h1004, 32'h2222_2222);
      rd(14'h1004, 32'h3333_3000, "R9 far capture wins");

      // R10 scratch and dead offsets
      wr(14'h008, 32'hCAFE_F00D);
      wr(14'h203C, 32'h0BAD_CAFE);
      rd(14'h008, 32'hCAFE_F00D, "R10 scratch page0");
      rd(14'h203C, 32'h0BAD_CAFE, "R10 scratch page2 last word");
      wr(14'h1040, 32'hFFFF_FFFF);
      rd(14'h1040, 32'h0, "R10 beyond scratch ignored");
      wr(14'h3000, 32'hFFFF_FFFF);
      rd(14'h3000, 32'h0, "R10 page3 ignored");

      // R11 low address bits ignored
      rd(14'h006, 32'h07FF_FC00, "R11 byte offset ignored");
      idle();
      idle();
      check("R11 scoreboard drained", 32'(exp_q.size()), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule